// File: doc/BRIEF.md
# Pixel Matrix Readout Sequencer

This block runs in the readout clock domain of a monolithic pixel sensor. The sensor has several sub-matrices that are read in parallel, 256 rows by 64 columns each. It drives the shared row and column addresses and a slot code. The slot code tells the analogue multiplexers whether the current slot carries one of the two leading marker levels or a pixel. A start token arms the sequencer. When the token falls, a fixed initialisation latency runs, and then frames are scanned back to back for as long as the clock runs. The token may be raised again at any time, and this aborts the scan.

The sequencer also drives the digital monitoring pins: a readout-ready flag, a start strobe, a first-slot/slot-rate marker, an end-of-row marker and a last-row marker. In test mode, pixel selection is replaced by a two-level pattern. Each sub-matrix gets a select bit that alternates on every slot, and the row and column markers are held low.

Top module: `rdo_seq`

## Requirements
- R1: While rst_n is low and until the first start token, kind_o is 0 (idle), and rst_done_o, ssync_o, first_o, last_col_o, last_row_o and test_lvl_o are all 0.
- R2: At any clock edge that samples sync_i high, the scan is abandoned. From the next cycle, kind_o is 0 and rst_done_o and ssync_o are 0, and they stay so while sync_i stays high.
- R3: The edge that first samples sync_i low after it was high starts the initialisation. For the 4 cycles after that edge, ssync_o is 1 and kind_o is 0. The first slot of the frame appears in the 5th cycle. rst_done_o is 1 from the first initialisation cycle until the next abort or reset.
- R4: Every row has 66 slots in this order: slot 0 has kind_o = 1 (marker one), slot 1 has kind_o = 2 (marker zero), and slots 2 to 65 have kind_o = 3 (pixel). During pixel slots col_o counts 63 down to 0. During marker slots col_o is 63.
- R5: row_o runs from 255 down to 0, one step per row. The slot after the last slot of row 0 is slot 0 of row 255, with no gap.
- R6: With mux_every_i = 0 and test_en_i = 0, first_o is 1 only in slot 0 of row 255.
- R7: With mux_every_i = 1 or test_en_i = 1, first_o is 1 on the even slot indices of every row while scanning and 0 on the odd ones.
- R8: last_col_o is 1 exactly in slot 65 of every row. last_row_o is 1 for every slot of row 0. Both are 0 whenever test_en_i = 1.
- R9: While scanning with test_en_i = 1, test_lvl_o[s] equals (s mod 2) XOR (slot index mod 2). Sub-matrices 3 and 1 therefore start a row on level 1, and sub-matrices 2 and 0 start on level 0. Otherwise test_lvl_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | readout clock |
| rst_n | input | 1 | asynchronous reset, active low |
| sync_i | input | 1 | start/restart token |
| mux_every_i | input | 1 | 1: first_o marks every even slot; 0: first slot of frame only |
| test_en_i | input | 1 | replace pixels by the alternating test levels |
| row_o | output | 8 | row address |
| col_o | output | 6 | column address inside a sub-matrix |
| kind_o | output | 2 | slot code: 0 idle, 1 marker one, 2 marker zero, 3 pixel |
| test_lvl_o | output | 4 | per-sub-matrix test level select |
| rst_done_o | output | 1 | readout logic reset finished |
| ssync_o | output | 1 | start strobe during initialisation |
| first_o | output | 1 | first-slot / slot-rate marker |
| last_col_o | output | 1 | last pixel of a row |
| last_row_o | output | 1 | last row of a frame |

## Verification
The bench follows two whole frames so that the wrap from row 0 to row 255 is observed. A counter that forgot to wrap, or that left an idle slot between frames, would put a wrong row or kind on the very next cycle. Restart tokens are injected in the middle of rows and during the initialisation window, with widths of one to several cycles. A sequencer that ignored a token while counting latency, or that counted the latency from the rising edge, would show the first marker slot one or more cycles off. Test mode and the slot-rate marker are switched at random while scanning. A design that left the row markers active in test mode, or that started the odd sub-matrices on the wrong level, is caught slot by slot.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_INIT  = 2'd2,
        PH_RUN   = 2'd3
    } rdo_phase_e;

    typedef enum logic [1:0] {
        SLOT_NONE = 2'd0,
        SLOT_MK1  = 2'd1,
        SLOT_MK0  = 2'd2,
        SLOT_PIX  = 2'd3
    } slot_kind_e;

    localparam int unsigned MARKER_SLOTS = 2;

endpackage

// File: rtl/rdo_sync_ctl.sv
module rdo_sync_ctl
    import rdo_pkg::*;
#(
    parameter int unsigned LATENCY = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    output rdo_phase_e phase_o
);
    localparam int unsigned LAT_W = $clog2(LATENCY + 1);

    typedef struct packed {
        rdo_phase_e       phase;
        logic [LAT_W-1:0] lat;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync_i) begin
            st_d.phase = PH_ARMED;
            st_d.lat   = '0;
        end else begin
            unique case (st_q.phase)
                PH_IDLE:  st_d = st_q;
                PH_ARMED: begin
                    st_d.phase = PH_INIT;
                    st_d.lat   = LAT_W'(LATENCY - 1);
                end
                PH_INIT: begin
                    if (st_q.lat == '0) st_d.phase = PH_RUN;
                    else                st_d.lat   = st_q.lat - 1'b1;
                end
                PH_RUN:   st_d = st_q;
                default:  st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.lat   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;

    // R2: a sampled token always leads to the armed phase
    assert_sync_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (st_q.phase == PH_ARMED));

    // R3: scanning is only ever entered from the initialisation phase
    assert_run_after_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_RUN) ##1 (st_q.phase == PH_RUN) |-> ($past(st_q.phase) == PH_INIT));

endmodule

// File: rtl/rdo_scan_cnt.sv
module rdo_scan_cnt #(
    parameter int unsigned ROWS  = 256,
    parameter int unsigned SLOTS = 66
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_i,
    output logic [$clog2(ROWS)-1:0]  row_o,
    output logic [$clog2(SLOTS)-1:0] slot_o
);
    localparam int unsigned ROW_W  = $clog2(ROWS);
    localparam int unsigned SLOT_W = $clog2(SLOTS);
    localparam logic [ROW_W-1:0]  ROW_TOP   = ROW_W'(ROWS - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [SLOT_W-1:0] slot;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d.row  = ROW_TOP;
            cnt_d.slot = '0;
        end else if (cnt_q.slot == SLOT_LAST) begin
            cnt_d.slot = '0;
            cnt_d.row  = (cnt_q.row == '0) ? ROW_TOP : cnt_q.row - 1'b1;
        end else begin
            cnt_d.slot = cnt_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q.row  <= ROW_TOP;
            cnt_q.slot <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign row_o  = cnt_q.row;
    assign slot_o = cnt_q.slot;

    // R4: slot index never leaves the row
    assert_slot_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.slot <= SLOT_LAST);

    // R5: end of the last row returns to the top row, slot zero
    assert_frame_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cnt_q.slot == SLOT_LAST && cnt_q.row == '0)
        |=> (cnt_q.row == ROW_TOP && cnt_q.slot == '0));

    // R5: rows step down by one (or reload after a stop)
    assert_row_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cnt_q.slot == SLOT_LAST && cnt_q.row != '0)
        |=> ((cnt_q.row == $past(cnt_q.row) - 1'b1) || (cnt_q.row == ROW_TOP && cnt_q.slot == '0)));

endmodule

// File: rtl/rdo_marker_gen.sv
module rdo_marker_gen
    import rdo_pkg::*;
#(
    parameter int unsigned ROWS = 256,
    parameter int unsigned COLS = 64,
    parameter int unsigned NSUB = 4
) (
    input  rdo_phase_e                                   phase_i,
    input  logic [$clog2(ROWS)-1:0]                      row_i,
    input  logic [$clog2(COLS + MARKER_SLOTS)-1:0]       slot_i,
    input  logic                                         mux_every_i,
    input  logic                                         test_en_i,
    output logic [1:0]                                   kind_o,
    output logic [$clog2(COLS)-1:0]                      col_o,
    output logic [NSUB-1:0]                              test_lvl_o,
    output logic                                         rst_done_o,
    output logic                                         ssync_o,
    output logic                                         first_o,
    output logic                                         last_col_o,
    output logic                                         last_row_o
);
    localparam int unsigned SLOTS  = COLS + MARKER_SLOTS;
    localparam int unsigned ROW_W  = $clog2(ROWS);
    localparam int unsigned COL_W  = $clog2(COLS);
    localparam int unsigned SLOT_W = $clog2(SLOTS);
    localparam logic [ROW_W-1:0]  ROW_TOP   = ROW_W'(ROWS - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
    localparam logic [SLOT_W-1:0] SLOT_PIX0 = SLOT_W'(MARKER_SLOTS);

    logic              run;
    logic [SLOT_W-1:0] col_wide;
    logic              per_slot;

    always_comb begin
        run      = (phase_i == PH_RUN);
        per_slot = mux_every_i || test_en_i;
        col_wide = SLOT_LAST - slot_i;

        kind_o = SLOT_NONE;
        col_o  = COL_W'(COLS - 1);
        if (run) begin
            if (slot_i == '0)              kind_o = SLOT_MK1;
            else if (slot_i < SLOT_PIX0)   kind_o = SLOT_MK0;
            else begin
                kind_o = SLOT_PIX;
                col_o  = col_wide[COL_W-1:0];
            end
        end

        rst_done_o = (phase_i == PH_INIT) || run;
        ssync_o    = (phase_i == PH_INIT);

        if (per_slot) first_o = run && !slot_i[0];
        else          first_o = run && (row_i == ROW_TOP) && (slot_i == '0);

        last_col_o = run && !test_en_i && (slot_i == SLOT_LAST);
        last_row_o = run && !test_en_i && (row_i == '0);
    end

    for (genvar s = 0; s < NSUB; s++) begin : g_lvl
        localparam logic START = 1'(s % 2);
        assign test_lvl_o[s] = (run && test_en_i) ? (START ^ slot_i[0]) : 1'b0;
    end

endmodule

// File: rtl/rdo_seq.sv
module rdo_seq
    import rdo_pkg::*;
#(
    parameter int unsigned ROWS    = 256,
    parameter int unsigned COLS    = 64,
    parameter int unsigned NSUB    = 4,
    parameter int unsigned LATENCY = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sync_i,
    input  logic                     mux_every_i,
    input  logic                     test_en_i,
    output logic [$clog2(ROWS)-1:0]  row_o,
    output logic [$clog2(COLS)-1:0]  col_o,
    output logic [1:0]               kind_o,
    output logic [NSUB-1:0]          test_lvl_o,
    output logic                     rst_done_o,
    output logic                     ssync_o,
    output logic                     first_o,
    output logic                     last_col_o,
    output logic                     last_row_o
);
    localparam int unsigned SLOTS  = COLS + MARKER_SLOTS;
    localparam int unsigned SLOT_W = $clog2(SLOTS);

    rdo_phase_e        phase;
    logic [SLOT_W-1:0] slot;

    rdo_sync_ctl #(.LATENCY(LATENCY)) i_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (sync_i),
        .phase_o (phase)
    );

    rdo_scan_cnt #(.ROWS(ROWS), .SLOTS(SLOTS)) i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (phase == PH_RUN),
        .row_o  (row_o),
        .slot_o (slot)
    );

    rdo_marker_gen #(.ROWS(ROWS), .COLS(COLS), .NSUB(NSUB)) i_mk (
        .phase_i     (phase),
        .row_i       (row_o),
        .slot_i      (slot),
        .mux_every_i (mux_every_i),
        .test_en_i   (test_en_i),
        .kind_o      (kind_o),
        .col_o       (col_o),
        .test_lvl_o  (test_lvl_o),
        .rst_done_o  (rst_done_o),
        .ssync_o     (ssync_o),
        .first_o     (first_o),
        .last_col_o  (last_col_o),
        .last_row_o  (last_row_o)
    );

    // R6: in frame-start mode the marker only lands on the first marker of the top row
    assert_first_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (first_o && !mux_every_i && !test_en_i)
        |-> (kind_o == SLOT_MK1 && row_o == $clog2(ROWS)'(ROWS - 1)));

    // R8: last-row marker only on row zero and never in test mode
    assert_last_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last_row_o |-> (row_o == '0 && !test_en_i));

    // R9: test levels stay low outside test mode
    assert_tlvl_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en_i |-> (test_lvl_o == '0));

    // R3: the first slot after initialisation is a marker-one slot
    assert_first_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ssync_o && !sync_i && phase == PH_INIT) ##1 (!ssync_o && rst_done_o)
        |-> (kind_o == SLOT_MK1));

endmodule

// File: tb/test_rdo_seq.sv
module test_rdo_seq;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_i = 1'b0;
    logic       mux_every_i = 1'b0;
    logic       test_en_i = 1'b0;
    logic [7:0] row_o;
    logic [5:0] col_o;
    logic [1:0] kind_o;
    logic [3:0] test_lvl_o;
    logic       rst_done_o, ssync_o, first_o, last_col_o, last_row_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rdo_seq i_rdo_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_i),
        .mux_every_i (mux_every_i),
        .test_en_i   (test_en_i),
        .row_o       (row_o),
        .col_o       (col_o),
        .kind_o      (kind_o),
        .test_lvl_o  (test_lvl_o),
        .rst_done_o  (rst_done_o),
        .ssync_o     (ssync_o),
        .first_o     (first_o),
        .last_col_o  (last_col_o),
        .last_row_o  (last_row_o)
    );

    // reference model: 0 idle, 1 armed, 2 init, 3 scanning
    int m_ph   = 0;
    int m_lat  = 0;
    int m_row  = 255;
    int m_slot = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0;
        end else if (sync_i) begin
            m_ph = 1;
        end else if (m_ph == 1) begin
            m_ph = 2; m_lat = 4;
        end else if (m_ph == 2) begin
            m_lat--;
            if (m_lat == 0) begin m_ph = 3; m_row = 255; m_slot = 0; end
        end else if (m_ph == 3) begin
            if (m_slot == 65) begin
                m_slot = 0;
                m_row  = (m_row == 0) ? 255 : m_row - 1;
            end else m_slot++;
        end
    end

    function automatic int exp_kind();
        if (m_ph != 3)   return 0;
        if (m_slot == 0) return 1;
        if (m_slot == 1) return 2;
        return 3;
    endfunction

    function automatic int exp_col();
        if (m_ph != 3 || m_slot < 2) return 63;
        return 65 - m_slot;
    endfunction

    function automatic int exp_first();
        if (m_ph != 3) return 0;
        if (mux_every_i || test_en_i) return (m_slot % 2 == 0) ? 1 : 0;
        return (m_row == 255 && m_slot == 0) ? 1 : 0;
    endfunction

    function automatic int exp_tlvl();
        int v = 0;
        if (m_ph != 3 || !test_en_i) return 0;
        for (int s = 0; s < 4; s++)
            if (((s % 2) ^ (m_slot % 2)) == 1) v |= (1 << s);
        return v;
    endfunction

    function automatic string tag_of(input string run_tag);
        if (!rst_n || m_ph == 0) return "R1";
        if (m_ph == 1)           return "R2";
        if (m_ph == 2)           return "R3";
        return run_tag;
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s %s got %0d exp %0d (row %0d slot %0d ph %0d) at %0t",
                     req, what, got, exp, m_row, m_slot, m_ph, $time);
        end
    endtask

    task automatic compare_all();
        chk(tag_of("R4"), "kind", int'(kind_o), exp_kind());
        chk(tag_of("R4"), "col", int'(col_o), exp_col());
        if (m_ph == 3) chk("R5", "row", int'(row_o), m_row);
        chk(tag_of((mux_every_i || test_en_i) ? "R7" : "R6"), "first", int'(first_o), exp_first());
        chk(tag_of("R8"), "last_col", int'(last_col_o),
            (m_ph == 3 && !test_en_i && m_slot == 65) ? 1 : 0);
        chk(tag_of("R8"), "last_row", int'(last_row_o),
            (m_ph == 3 && !test_en_i && m_row == 0) ? 1 : 0);
        chk(tag_of("R9"), "test_lvl", int'(test_lvl_o), exp_tlvl());
        chk(tag_of("R3"), "ssync", int'(ssync_o), (m_ph == 2) ? 1 : 0);
        chk(tag_of("R3"), "rst_done", int'(rst_done_o), (m_ph >= 2) ? 1 : 0);
    endtask

    task automatic run_cycles(input int n);
        repeat (n) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic pulse_sync(input int width);
        sync_i = 1'b1;
        run_cycles(width);
        sync_i = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20061));
        // R1: reset state and idle after reset
        run_cycles(4);
        rst_n = 1'b1;
        run_cycles(3);

        // R3 R4 R5 R6 R8: two full frames in frame-start mode plus the wrap
        pulse_sync(3);
        run_cycles(2 * 256 * 66 + 12);

        // R2: abort in the middle of a row, slot-rate marker (R7)
        mux_every_i = 1'b1;
        run_cycles(137);
        pulse_sync(2);
        run_cycles(300);

        // R2 R3: token during the initialisation window
        pulse_sync(1);
        run_cycles(2);
        pulse_sync(1);
        run_cycles(200);

        // R9: test mode over more than one row
        test_en_i   = 1'b1;
        mux_every_i = 1'b0;
        pulse_sync(1);
        run_cycles(400);

        // random segments
        for (int it = 0; it < 14; it++) begin
            mux_every_i = 1'($urandom_range(0, 1));
            test_en_i   = 1'($urandom_range(0, 1));
            run_cycles($urandom_range(1, 3000));
            pulse_sync($urandom_range(1, 4));
        end

        // R1: reset during a scan
        run_cycles(50);
        rst_n = 1'b0;
        run_cycles(2);
        rst_n = 1'b1;
        run_cycles(5);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule